// File: doc/BRIEF.md
# Serial Symbol Framer with Early-Warning Flag

This block recovers symbol framing from a serial bit stream that carries no boundary marker of its own. One bit is sampled on every rising edge of the bit clock. The last received bits are compared, at every bit, against a reserved synchronisation code that is selected by a mode input. When the code is seen, a bit counter is restarted, and that counter then marks every later symbol boundary. Each boundary, and each sync detection, copies the framed bits into a holding register for a downstream decoder and raises a one-cycle load strobe. A byte-rate clock is derived from the same events.

An active-low early-warning flag tells the host whether sync fill or real traffic is arriving. Once the stream is framed, the flag is judged halfway through each symbol from the leading half of that symbol. It falls on the leading half of a sync and rises on the leading half of any other symbol. This happens about half a symbol before that symbol reaches the holding register. An active-low test input holds the flag low.

Top module: `ser_framer`

## Requirements
- R1: After synchronous reset `sym_word` is 0 and `load_stb`, `byte_clk` and `warn_n` are 0. Until the first sync code has been seen, `load_stb` never rises, whatever bits arrive.
- R2: A sync code is found at any bit offset by comparing the last L received bits with the code, where L is the symbol length. The rising edge after the one that samples its final bit sets `load_stb` for one cycle and loads `sym_word` with the code. The first-received bit goes to bit L-1 and the bits above L-1 are zero.
- R3: Once framed, exactly one load happens every L bits with no load in between. Each load holds the L bits received since the previous boundary, in the same bit order as R2.
- R4: `mode` 0 selects L=10 with sync 10'b1100010001, `mode` 1 selects L=11 with sync 11'b11000100010, and `mode` 2 selects L=12 with sync 12'b110000100010. `mode` 3 behaves as `mode` 0.
- R5: A sync at a new bit offset re-aligns all later boundaries to its own end, even when it lands on the halfway point of the old framing.
- R6: `byte_clk` rises together with every `load_stb` and stays high for floor(L/2) cycles. When no sync has intervened, it is then low until the next load.
- R7: `warn_n` is 0 in the cycle after a sync code is detected. Once framed, it falls one edge after the leading floor(L/2) bits of a framed symbol equal the leading floor(L/2) bits of the sync code.
- R8: Once framed, `warn_n` rises one edge after the leading floor(L/2) bits of a symbol arrive and differ from the sync's leading half. This is before that symbol is loaded. A run of non-sync symbols keeps it high and a run of syncs keeps it low.
- R9: While `test_n` is 0, `warn_n` is forced to 0 from the next edge on, and loads continue. After `test_n` returns to 1, `warn_n` stays 0 until the next non-sync leading half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | recovered bit clock |
| rst | input | 1 | synchronous reset, active high |
| ser_in | input | 1 | serial data bit |
| mode | input | 2 | symbol length select (0:10, 1:11, 2:12, 3:10) |
| test_n | input | 1 | active-low test input, forces the flag low |
| sym_word | output | 12 | framed symbol for the decoder, right-aligned |
| load_stb | output | 1 | one-cycle strobe, `sym_word` is new |
| byte_clk | output | 1 | symbol-rate clock aligned to loads |
| warn_n | output | 1 | active-low early-warning flag (low: sync fill) |

## Verification
A sync detection and a scheduled halfway check of the old framing can land on the same edge. This pits a forced low flag and a fresh load against a non-sync verdict on the old framing's leading half. The bench provokes this by inserting five spare bits after a data symbol in 10-bit mode, so that the misaligned sync completes exactly on the old framing's halfway point. It then expects a low flag, a sync load with the byte clock high, a junk load at the old boundary beforehand, and the following data symbol loaded exactly ten bits later on the new alignment.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned MAXW = 12;
  localparam int unsigned CW   = $clog2(MAXW);

  typedef enum logic [1:0] {
    MODE_10  = 2'd0,
    MODE_11  = 2'd1,
    MODE_12  = 2'd2,
    MODE_ALT = 2'd3
  } sym_mode_e;

  // symbol length in bits for a mode code
  function automatic int unsigned sym_len(logic [1:0] m);
    case (m)
      MODE_11: return 11;
      MODE_12: return 12;
      default: return 10;
    endcase
  endfunction

  // length of the leading half used by the early-warning check
  function automatic int unsigned half_len(logic [1:0] m);
    return sym_len(m) / 2;
  endfunction

  // ones in the low n bits
  function automatic logic [MAXW-1:0] low_mask(int unsigned n);
    logic [MAXW:0] t;
    t = (MAXW+1)'(1) << n;
    return MAXW'(t - (MAXW+1)'(1));
  endfunction
endpackage

// File: rtl/sfr_shift_detect.sv
module sfr_shift_detect
  import sfr_pkg::*;
#(
  parameter logic [MAXW-1:0] SYNC_A = 12'h311,
  parameter logic [MAXW-1:0] SYNC_B = 12'h622,
  parameter logic [MAXW-1:0] SYNC_C = 12'hC22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_in,
  input  logic [1:0]      mode,
  output logic [MAXW-1:0] window,
  output logic            sync_hit,
  output logic            head_match
);
  logic [MAXW-1:0] sh_q;
  logic [MAXW-1:0] code;
  int unsigned     len_c;
  int unsigned     half_c;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[MAXW-2:0], ser_in};
  end

  always_comb begin
    case (mode)
      MODE_11: code = SYNC_B;
      MODE_12: code = SYNC_C;
      default: code = SYNC_A;
    endcase
    len_c      = sym_len(mode);
    half_c     = half_len(mode);
    window     = sh_q & low_mask(len_c);
    sync_hit   = (window == code);
    head_match = ((sh_q & low_mask(half_c)) == (code >> (len_c - half_c)));
  end
endmodule

// File: rtl/sfr_bit_counter.sv
module sfr_bit_counter
  import sfr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          sync_hit,
  output logic [CW-1:0] cnt,
  output logic          locked,
  output logic          boundary,
  output logic          half_pt
);
  logic [CW-1:0] last_c;
  logic [CW-1:0] half_c;

  always_comb begin
    last_c   = CW'(sym_len(mode) - 1);
    half_c   = CW'(half_len(mode));
    boundary = locked && (cnt == '0);
    half_pt  = locked && (cnt == half_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (sync_hit) begin
      cnt    <= CW'(1);
      locked <= 1'b1;
    end else if (locked) begin
      cnt <= (cnt == last_c) ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sfr_warn_flag.sv
module sfr_warn_flag (
  input  logic clk,
  input  logic rst,
  input  logic test_n,
  input  logic sync_hit,
  input  logic half_pt,
  input  logic head_match,
  output logic warn_n
);
  always_ff @(posedge clk) begin
    if (rst)           warn_n <= 1'b0;
    else if (!test_n)  warn_n <= 1'b0;
    else if (sync_hit) warn_n <= 1'b0;
    else if (half_pt)  warn_n <= !head_match;
  end
endmodule

// File: rtl/sfr_out_stage.sv
module sfr_out_stage
  import sfr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load_evt,
  input  logic            half_pt,
  input  logic [MAXW-1:0] window,
  output logic [MAXW-1:0] sym_word,
  output logic            load_stb,
  output logic            byte_clk
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sym_word <= '0;
      load_stb <= 1'b0;
      byte_clk <= 1'b0;
    end else begin
      load_stb <= load_evt;
      if (load_evt) begin
        sym_word <= window;
        byte_clk <= 1'b1;
      end else if (half_pt) begin
        byte_clk <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ser_framer.sv
module ser_framer
  import sfr_pkg::*;
#(
  parameter logic [MAXW-1:0] SYNC_A = 12'h311,
  parameter logic [MAXW-1:0] SYNC_B = 12'h622,
  parameter logic [MAXW-1:0] SYNC_C = 12'hC22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_in,
  input  logic [1:0]      mode,
  input  logic            test_n,
  output logic [MAXW-1:0] sym_word,
  output logic            load_stb,
  output logic            byte_clk,
  output logic            warn_n
);
  logic [MAXW-1:0] window;
  logic            sync_hit;
  logic            head_match;
  logic [CW-1:0]   cnt;
  logic            locked;
  logic            boundary;
  logic            half_pt;
  logic            load_evt;

  assign load_evt = sync_hit || boundary;

  sfr_shift_detect #(
    .SYNC_A(SYNC_A), .SYNC_B(SYNC_B), .SYNC_C(SYNC_C)
  ) i_detect (
    .clk(clk), .rst(rst), .ser_in(ser_in), .mode(mode),
    .window(window), .sync_hit(sync_hit), .head_match(head_match)
  );

  sfr_bit_counter i_count (
    .clk(clk), .rst(rst), .mode(mode), .sync_hit(sync_hit),
    .cnt(cnt), .locked(locked), .boundary(boundary), .half_pt(half_pt)
  );

  sfr_warn_flag i_warn (
    .clk(clk), .rst(rst), .test_n(test_n), .sync_hit(sync_hit),
    .half_pt(half_pt), .head_match(head_match), .warn_n(warn_n)
  );

  sfr_out_stage i_out (
    .clk(clk), .rst(rst), .load_evt(load_evt), .half_pt(half_pt),
    .window(window), .sym_word(sym_word), .load_stb(load_stb),
    .byte_clk(byte_clk)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker
  import sfr_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            test_n,
  input logic [1:0]      mode,
  input logic            sync_hit,
  input logic            locked,
  input logic [CW-1:0]   cnt,
  input logic [MAXW-1:0] window,
  input logic [MAXW-1:0] sym_word,
  input logic            load_stb,
  input logic            byte_clk,
  input logic            warn_n
);
  AST_NO_LOAD_UNFRAMED: assert property (@(posedge clk) disable iff (rst) load_stb |-> locked); // R1
  AST_SYNC_LOADS: assert property (@(posedge clk) disable iff (rst) sync_hit |=> (load_stb && sym_word == $past(window))); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt < CW'(sym_len(mode))); // R3
  AST_BCLK_HIGH_ON_LOAD: assert property (@(posedge clk) disable iff (rst) load_stb |-> byte_clk); // R6
  AST_BCLK_RISE_ON_LOAD: assert property (@(posedge clk) disable iff (rst) $rose(byte_clk) |-> load_stb); // R6
  AST_SYNC_WARN_LOW: assert property (@(posedge clk) disable iff (rst) sync_hit |=> !warn_n); // R7
  AST_TEST_FORCES_LOW: assert property (@(posedge clk) disable iff (rst) !test_n |=> !warn_n); // R9
endmodule

bind ser_framer sfr_checker i_chk (.*);

// File: tb/test_ser_framer.sv
module test_ser_framer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_in = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        test_n = 1'b1;
  logic [11:0] sym_word;
  logic        load_stb;
  logic        byte_clk;
  logic        warn_n;

  int checks = 0;
  int errors = 0;

  ser_framer i_ser_framer (
    .clk(clk), .rst(rst), .ser_in(ser_in), .mode(mode), .test_n(test_n),
    .sym_word(sym_word), .load_stb(load_stb), .byte_clk(byte_clk), .warn_n(warn_n)
  );

  always #10 clk = ~clk;

  localparam int SYNC10 = 'h311;
  localparam int SYNC11 = 'h622;
  localparam int SYNC12 = 'hC22;

  // {is_sync, word} in 10-bit mode
  localparam logic [12:0] VEC [10] = '{
    {1'b0, 12'h155}, {1'b0, 12'h092}, {1'b1, 12'h311}, {1'b1, 12'h311},
    {1'b0, 12'h155}, {1'b0, 12'h092}, {1'b0, 12'h2AA}, {1'b0, 12'h124},
    {1'b1, 12'h311}, {1'b0, 12'h155}
  };

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(logic b);
    ser_in = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(logic [1:0] m);
    rst = 1'b1;
    mode = m;
    test_n = 1'b1;
    tick(1'b0);
    tick(1'b0);
    rst = 1'b0;
  endtask

  task automatic send_sym(int w, int len);
    for (int i = len - 1; i >= 0; i--) tick(w[i]);
  endtask

  task automatic run_mode(logic [1:0] m, int len, int sy, int dw);
    int loads;
    do_reset(m);
    send_sym(sy, len);
    loads = 0;
    for (int i = 0; i < len; i++) begin
      tick(dw[len-1-i]);
      if (i == 0) begin
        chk("R4", "sync load strobe", int'(load_stb), 1);
        chk("R4", "sync word", int'(sym_word), sy);
      end else loads += int'(load_stb);
      if (i == len/2 - 1) chk("R8", "flag before leading half", int'(warn_n), 0);
      if (i == len/2) chk("R8", "flag after leading half", int'(warn_n), 1);
    end
    chk("R4", "no load inside symbol", loads, 0);
    tick(1'b0);
    chk("R4", "data load strobe", int'(load_stb), 1);
    chk("R4", "data word", int'(sym_word), dw);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit locked_m;
    bit have_prev;
    bit prev_sync;
    int prev;
    int loads;
    @(negedge clk);
    do_reset(2'd0);

    // R1 reset state
    chk("R1", "sym_word after reset", int'(sym_word), 0);
    chk("R1", "load_stb after reset", int'(load_stb), 0);
    chk("R1", "byte_clk after reset", int'(byte_clk), 0);
    chk("R1", "warn_n after reset", int'(warn_n), 0);

    // table walk, 10-bit mode
    locked_m = 1'b0; have_prev = 1'b0; prev_sync = 1'b0; prev = 0;
    foreach (VEC[e]) begin
      int w;
      bit s;
      w = int'(VEC[e][11:0]);
      s = VEC[e][12];
      loads = 0;
      for (int i = 0; i < 10; i++) begin
        tick(w[9-i]);
        if (i == 0) begin
          if (have_prev) begin
            chk(prev_sync ? "R2" : "R3", "load strobe at boundary", int'(load_stb), 1);
            chk(prev_sync ? "R2" : "R3", "loaded word", int'(sym_word), prev);
          end else chk("R1", "no load before sync", int'(load_stb), 0);
        end else loads += int'(load_stb);
        if (i == 4) chk("R6", "byte_clk high half", int'(byte_clk), int'(have_prev));
        if (i == 5) chk("R6", "byte_clk low half", int'(byte_clk), 0);
        if (i == 4 && locked_m && prev_sync && !s) chk("R8", "flag still low before half", int'(warn_n), 0);
        if (i == 5) chk(s ? "R7" : "R8", "flag at leading half", int'(warn_n), int'(locked_m && !s));
      end
      chk("R3", "no extra load within symbol", loads, 0);
      if (s) locked_m = 1'b1;
      have_prev = locked_m;
      prev_sync = s;
      prev = w;
    end
    tick(1'b0);
    chk("R3", "final load strobe", int'(load_stb), 1);
    chk("R3", "final word", int'(sym_word), prev);

    // R4 other lengths and the spare mode code
    run_mode(2'd1, 11, SYNC11, 'h2AA);
    run_mode(2'd2, 12, SYNC12, 'h555);
    run_mode(2'd3, 10, SYNC10, 'h155);

    // R5 re-alignment landing on the old halfway point
    do_reset(2'd0);
    send_sym(SYNC10, 10);
    send_sym('h155, 10);
    chk("R8", "flag high after data half", int'(warn_n), 1);
    for (int i = 0; i < 5; i++) begin
      tick(1'b0);
      if (i == 0) chk("R3", "data word before resync", int'(sym_word), 'h155);
    end
    for (int i = 0; i < 10; i++) begin
      tick(SYNC10[9-i]);
      if (i == 5) begin
        chk("R3", "old boundary load", int'(load_stb), 1);
        chk("R3", "old boundary word", int'(sym_word), 'h018);
      end
    end
    loads = 0;
    for (int i = 0; i < 10; i++) begin
      tick(('h092 >> (9-i)) & 1);
      if (i == 0) begin
        chk("R5", "sync load on new offset", int'(load_stb), 1);
        chk("R5", "sync word on new offset", int'(sym_word), SYNC10);
        chk("R5", "flag low despite old half", int'(warn_n), 0);
        chk("R6", "byte_clk with sync load", int'(byte_clk), 1);
      end else loads += int'(load_stb);
      if (i == 5) chk("R8", "flag rises on new framing", int'(warn_n), 1);
    end
    chk("R5", "no load inside re-aligned symbol", loads, 0);
    tick(1'b0);
    chk("R5", "data load on new alignment", int'(load_stb), 1);
    chk("R5", "data word on new alignment", int'(sym_word), 'h092);

    // R9 test input forces the flag low, loads continue
    do_reset(2'd0);
    send_sym(SYNC10, 10);
    send_sym('h155, 10);
    chk("R9", "flag high before test", int'(warn_n), 1);
    for (int i = 0; i < 10; i++) begin
      if (i == 1) test_n = 1'b0;
      tick(('h092 >> (9-i)) & 1);
      if (i == 1) chk("R9", "flag forced low", int'(warn_n), 0);
      if (i == 5) chk("R9", "flag held low at half", int'(warn_n), 0);
    end
    for (int i = 0; i < 10; i++) begin
      if (i == 1) test_n = 1'b1;
      tick(('h124 >> (9-i)) & 1);
      if (i == 0) begin
        chk("R9", "load continues in test", int'(load_stb), 1);
        chk("R9", "word loaded in test", int'(sym_word), 'h092);
      end
      if (i == 4) chk("R9", "flag low until next half", int'(warn_n), 0);
      if (i == 5) chk("R8", "flag rises after test", int'(warn_n), 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule